// File: doc/BRIEF.md
# Peg-Match Black/White Scorer

This block scores one guess against a hidden code in a four-position colour-matching game. Both the code and the guess are packed vectors of pegs, each peg a small colour number. The block reports how many pegs carry the right colour in the right position (black) and how many further pegs carry a colour that occurs in the code but sits in another position (white). A full positional match raises a win flag.

Exact matches are found first and mark their pegs as consumed on both sides. The guess is then rotated against the code by one, two and three peg positions in turn. Each rotation may pair a code peg with a guess peg only when both are still free, and each pairing consumes both pegs. This keeps repeated colours from being counted twice. A summing stage counts the flags. The inputs are sampled on a start strobe, and the registered result appears one cycle later together with a one-cycle done pulse. Sequencing of a whole game is left to the surrounding logic.

Top module: `peg_scorer`

## Requirements
- R1: Peg k of a packed vector occupies bits [2k+1:2k] (k = 0..3). `black` equals the number of positions k where guess peg k equals secret peg k.
- R2: `white` equals, summed over the four colours, min(count in secret, count in guess), minus `black`. Repeated colours are included.
- R3: `black + white` never exceeds 4.
- R4: When `start` is high at a rising edge, `done` is high for the following cycle, and the results reflect the `guess` and `secret` sampled at that edge. When `start` is low at an edge, `done` is low in the following cycle.
- R5: While `start` is low, `black`, `white` and `win` keep their values whatever `guess` and `secret` do.
- R6: `win` is high exactly when `black` is 4, and `white` is then 0.
- R7: A low `rst_n` at a rising edge clears `done`, `black`, `white` and `win` to 0 and takes priority over `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Sample the guess and secret and score them |
| guess | input | 8 | Guess pegs, peg k at bits [2k+1:2k] |
| secret | input | 8 | Secret pegs, peg k at bits [2k+1:2k] |
| done | output | 1 | High for one cycle after each start |
| black | output | 3 | Count of exact matches |
| white | output | 3 | Count of colour-only matches |
| win | output | 1 | All pegs match exactly |

## Verification
Two functions can fall in the same cycle. A new start can arrive while `done` and the previous result are still shown, and a reset can coincide with a start. The bench sweeps every guess and secret pair with a start in every cycle, so each score overwrites the previous one at the edge where `done` from the previous one is still high. The bench compares each result with a count computed by colour histogram. It also asserts reset together with start and expects all outputs cleared. Between these sweeps it changes the inputs with start low and expects the outputs to hold.

// File: rtl/peg_score_pkg.sv
// Package: shared sizing helpers for the peg scorer.
// Assumes: counts run from 0 to the number of pegs inclusive.
package peg_score_pkg;
    // Width needed to hold a count from 0 to n inclusive.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/peg_exact_match.sv
// Module: peg_exact_match
// Flags every position whose guess peg equals the secret peg.
// Assumes: pegs are packed at equal stride, peg k at [k*CW +: CW].
module peg_exact_match #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N*CW-1:0] guess,
    input  logic [N*CW-1:0] secret,
    output logic [N-1:0]    hit
);
    for (genvar k = 0; k < N; k++) begin : g_pos
        // Compare one position.
        assign hit[k] = (guess[k*CW +: CW] == secret[k*CW +: CW]);
    end
endmodule

// File: rtl/peg_rotate_match.sv
// Module: peg_rotate_match
// Finds colour-only matches. The guess is rotated by 1..N-1 pegs against
// the secret. A pair counts only if both pegs are still unused, and a
// counted pair marks both pegs used.
// Assumes: used_init flags the exact matches, the same set on both sides.
module peg_rotate_match #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N*CW-1:0] guess,
    input  logic [N*CW-1:0] secret,
    input  logic [N-1:0]    used_init,
    output logic [N-1:0]    white_hit
);
    logic [N-1:0] s_used [N];
    logic [N-1:0] g_used [N];
    logic [N-1:0] rot_hit [N];

    assign s_used[0]  = used_init;
    assign g_used[0]  = used_init;
    assign rot_hit[0] = '0;

    for (genvar r = 1; r < N; r++) begin : g_rot
        for (genvar i = 0; i < N; i++) begin : g_peg
            localparam int J = (i + r) % N;
            // Pair secret peg i with guess peg J when both are free.
            assign rot_hit[r][i] = !s_used[r-1][i] && !g_used[r-1][J] &&
                                   (secret[i*CW +: CW] == guess[J*CW +: CW]);
            assign s_used[r][i]  = s_used[r-1][i] | rot_hit[r][i];
            assign g_used[r][J]  = g_used[r-1][J] | rot_hit[r][i];
        end
    end

    // Secret pegs consumed by a rotation, excluding the exact matches.
    assign white_hit = s_used[N-1] & ~used_init;

    // R2: both sides must consume the same number of pegs.
    always_comb begin
        if (!$isunknown({guess, secret, used_init})) begin
            a_r2_mask_balance: assert ($countones(s_used[N-1]) == $countones(g_used[N-1]));
        end
    end
endmodule

// File: rtl/peg_popcount.sv
// Module: peg_popcount
// Counts the set bits of a flag vector with a summing chain.
// Assumes: W is wide enough to hold N.
module peg_popcount #(
    parameter int N = 4,
    parameter int W = 3
) (
    input  logic [N-1:0] flags,
    output logic [W-1:0] count
);
    // Sum the flags.
    always_comb begin
        count = '0;
        for (int k = 0; k < N; k++) begin
            count = count + W'(flags[k]);
        end
    end
endmodule

// File: rtl/peg_scorer.sv
// Module: peg_scorer (top)
// Scores a guess against a secret as black and white counts. The inputs
// are sampled on start, and the registered result appears one cycle later
// with a done pulse.
// Assumes: the caller holds the result as needed; no game sequencing here.
module peg_scorer
    import peg_score_pkg::*;
#(
    parameter int NUM_PEGS = 4,
    parameter int COLOR_W  = 2,
    localparam int VEC_W   = NUM_PEGS * COLOR_W,
    localparam int CNT_W   = count_width(NUM_PEGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] guess,
    input  logic [VEC_W-1:0] secret,
    output logic             done,
    output logic [CNT_W-1:0] black,
    output logic [CNT_W-1:0] white,
    output logic             win
);
    logic [NUM_PEGS-1:0] exact_hit;
    logic [NUM_PEGS-1:0] color_hit;
    logic [CNT_W-1:0]    black_nx;
    logic [CNT_W-1:0]    white_nx;

    peg_exact_match #(.N(NUM_PEGS), .CW(COLOR_W)) u_exact (
        .guess  (guess),
        .secret (secret),
        .hit    (exact_hit)
    );

    peg_rotate_match #(.N(NUM_PEGS), .CW(COLOR_W)) u_rotate (
        .guess     (guess),
        .secret    (secret),
        .used_init (exact_hit),
        .white_hit (color_hit)
    );

    peg_popcount #(.N(NUM_PEGS), .W(CNT_W)) u_cnt_black (
        .flags (exact_hit),
        .count (black_nx)
    );

    peg_popcount #(.N(NUM_PEGS), .W(CNT_W)) u_cnt_white (
        .flags (color_hit),
        .count (white_nx)
    );

    // Result registers: cleared on reset, loaded on start, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            black <= '0;
            white <= '0;
            win   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                black <= black_nx;
                white <= white_nx;
                win   <= &exact_hit;
            end
        end
    end

    // R3: the two counts never exceed the peg count together.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, black} + {1'b0, white}) <= (CNT_W+1)'(NUM_PEGS));

    // R4: done follows start by exactly one cycle.
    a_r4_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r4_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R5: without start the result holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(black) && $stable(white) && $stable(win)));

    // R6: win agrees with the black count and excludes whites.
    a_r6_win_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        win == (black == CNT_W'(NUM_PEGS)));
    a_r6_win_no_white: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> (white == '0));
endmodule

// File: tb/peg_scorer_bench.sv
// Bench: an exhaustive sweep of guess and secret pairs, with expected counts
// from colour histograms, followed by hold, reset and pulse checks.
module peg_scorer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] guess = '0;
    logic [7:0] secret = '0;
    logic       done;
    logic [2:0] black;
    logic [2:0] white;
    logic       win;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    peg_scorer u_peg_scorer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .guess  (guess),
        .secret (secret),
        .done   (done),
        .black  (black),
        .white  (white),
        .win    (win)
    );

    function automatic int exp_black(input logic [7:0] g, input logic [7:0] s);
        int n = 0;
        for (int k = 0; k < 4; k++) if (g[2*k +: 2] == s[2*k +: 2]) n++;
        return n;
    endfunction

    function automatic int exp_common(input logic [7:0] g, input logic [7:0] s);
        int tot = 0;
        for (int c = 0; c < 4; c++) begin
            int cg = 0;
            int cs = 0;
            for (int k = 0; k < 4; k++) begin
                if (g[2*k +: 2] == 2'(c)) cg++;
                if (s[2*k +: 2] == 2'(c)) cs++;
            end
            tot += (cg < cs) ? cg : cs;
        end
        return tot;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a score at the negedge; the result is checked one edge later.
    task automatic score(input logic [7:0] g, input logic [7:0] s);
        guess  = g;
        secret = s;
        start  = 1'b1;
        @(negedge clk);
        begin
            int eb = exp_black(g, s);
            int ew = exp_common(g, s) - eb;
            check("R4 done", int'(done), 1);
            check("R1 black", int'(black), eb);
            check("R2 white", int'(white), ew);
            check("R3 sum", int'(black) + int'(white) <= 4 ? 1 : 0, 1);
            check("R6 win", int'(win), eb == 4 ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 done", int'(done), 0);
        check("R7 black", int'(black), 0);
        check("R7 white", int'(white), 0);
        check("R7 win", int'(win), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Named repeated-colour cases (R2)
        score(8'b00_00_01_01, 8'b01_01_00_00);  // two reds, two blues swapped: 0 black, 4 white
        check("R2 swap", int'(white), 4);
        score(8'b00_00_00_00, 8'b11_10_01_00);  // guess all one colour: 1 black, 0 white
        check("R2 mono", int'(white), 0);
        score(8'b11_10_01_00, 8'b11_10_01_00);  // full match wins
        check("R6 full", int'(win), 1);

        // Exhaustive sweep, start in every cycle, back to back (R1 R2 R4)
        for (int p = 0; p < 65536; p++) begin
            score(p[15:8], p[7:0]);
        end
        start = 1'b0;
        @(negedge clk);
        check("R4 idle", int'(done), 0);

        // R5: inputs change with start low; the outputs must hold
        score(8'b01_11_10_00, 8'b00_11_01_10);  // 1 black, 3 white
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            guess  = 8'(k * 37);
            secret = 8'(k * 53 + 1);
            @(negedge clk);
            check("R5 done", int'(done), 0);
            check("R5 black", int'(black), 1);
            check("R5 white", int'(white), 3);
            check("R5 win", int'(win), 0);
        end

        // R7: reset coincides with start
        score(8'h1B, 8'h1B);
        rst_n  = 1'b0;
        start  = 1'b1;
        @(negedge clk);
        check("R7 prio done", int'(done), 0);
        check("R7 prio black", int'(black), 0);
        check("R7 prio win", int'(win), 0);
        rst_n = 1'b1;
        start = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule